// File: doc/BRIEF.md
# Read Data Return Scheduler

This block models the return path of read data in a memory rank. Each read that the rank accepts is given a tag and placed at the tail of an in-order pending queue together with a latency countdown loaded with the read latency. Every clock, all pending countdowns step down by one. Only the oldest entry is examined: when its countdown runs out, it leaves the queue and takes the single outgoing data-bus slot.

A read on the bus keeps the slot busy for a fixed burst duration (half the burst length, in clocks). When that time has elapsed the slot is released and a one-cycle delivery strobe carries the tag back to the controller. Within one clock edge the bus countdown and delivery are settled first, then the queue countdowns are stepped and the oldest entry is tested. A bus slot that ends on that same edge can therefore be refilled at once.

Two faults are flagged with one-cycle error pulses. The first is a read offered while the queue is full, which is dropped. The second is an oldest entry whose latency expires while the bus is still held beyond the current edge, which is dropped without disturbing the read already on the bus.

Top module: `read_return_sched`

## Requirements
- R1: After reset, `busBusy`, `deliverValid`, `overflowErr` and `collisionErr` are all 0.
- R2: A read accepted at clock edge E with the bus free takes the bus at edge E+RL, so `busBusy` reads 1 from the cycle after that edge. A read accepted at edge E is not stepped down at edge E.
- R3: A read holds the bus for exactly BURST edges. After its last edge, `deliverValid` is 1 for exactly one cycle and `deliverTag` equals the tag given at acceptance.
- R4: Deliveries come out in acceptance order.
- R5: A read whose latency expires on the same edge that the bus slot ends takes the bus with no idle cycle. Two reads accepted BURST edges apart are therefore delivered BURST cycles apart with no collision.
- R6: An accept made while the queue already holds DEPTH entries (counted before the edge) is dropped, is never delivered, and gives a one-cycle `overflowErr` pulse in the next cycle.
- R7: An oldest entry that expires while the bus stays held past the current edge is dropped and gives a one-cycle `collisionErr` pulse. The read on the bus is still delivered on time with its own tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acceptValid | input | 1 | A read is accepted on this edge |
| acceptTag | input | TAG_W | Tag of the accepted read |
| busBusy | output | 1 | Outgoing data-bus slot is occupied |
| deliverValid | output | 1 | One-cycle delivery strobe |
| deliverTag | output | TAG_W | Tag of the delivered read |
| overflowErr | output | 1 | Pulse: an accept was dropped because the queue was full |
| collisionErr | output | 1 | Pulse: an expired entry was dropped because the bus was held |

## Verification
The bench aims at the edge where a bus slot ends and the next entry expires together. A design that stepped the queue before releasing the bus would report a false collision there, or leave an idle cycle. It also accepts reads one cycle apart, so that one expires onto a held bus, and checks that the bus tag is not overwritten and the delivery is not lost. It fills the queue past its depth while entries are still counting, where an off-by-one full test would either drop a legal read or admit one too many. It also measures accept-to-delivery latency exactly, which catches a countdown that is stepped on its own load edge.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  typedef struct packed {
    logic push;     // append accepted read at tail
    logic pop;      // remove head entry
    logic load;     // place popped head on the bus slot
    logic deliver;  // bus slot ends this edge
  } rrsStrobes_t;
endpackage

// File: rtl/rrs_ctrl.sv
module rrs_ctrl
  import rrs_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int BURST = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acceptValid,
  input  logic        headAtOne,
  output rrsStrobes_t st,
  output logic        busBusy,
  output logic        deliverValid,
  output logic        overflowErr,
  output logic        collisionErr
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int BUS_W = $clog2(BURST + 1);

  logic [CNT_W-1:0] occupancy;
  logic [BUS_W-1:0] busLeft;
  logic busEnding, slotFree, queueFull, headExpire;

  always_comb begin
    busEnding  = (busLeft == BUS_W'(1));
    slotFree   = (busLeft == '0) || busEnding;
    queueFull  = (occupancy == CNT_W'(DEPTH));
    headExpire = (occupancy != '0) && headAtOne;
    st.push    = acceptValid && !queueFull;
    st.pop     = headExpire;
    st.load    = headExpire && slotFree;
    st.deliver = busEnding;
  end

  assign busBusy = (busLeft != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occupancy    <= '0;
      busLeft      <= '0;
      deliverValid <= 1'b0;
      overflowErr  <= 1'b0;
      collisionErr <= 1'b0;
    end else begin
      occupancy    <= occupancy + CNT_W'(st.push) - CNT_W'(st.pop);
      if (st.load)
        busLeft <= BUS_W'(BURST);
      else if (busLeft != '0)
        busLeft <= busLeft - BUS_W'(1);
      deliverValid <= busEnding;
      overflowErr  <= acceptValid && queueFull;
      collisionErr <= headExpire && !slotFree;
    end
  end
endmodule

// File: rtl/rrs_datapath.sv
module rrs_datapath
  import rrs_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int TAG_W = 8,
  parameter int RL    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rrsStrobes_t      st,
  input  logic [TAG_W-1:0] acceptTag,
  output logic             headAtOne,
  output logic [TAG_W-1:0] deliverTag
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LAT_W = $clog2(RL + 1);

  logic [TAG_W-1:0] tagMem [DEPTH];
  logic [LAT_W-1:0] latMem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [TAG_W-1:0] busTag;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign headAtOne = (latMem[rdPtr] == LAT_W'(1));

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        latMem[i] <= '0;
        tagMem[i] <= '0;
      end else if (st.push && wrPtr == PTR_W'(i)) begin
        latMem[i] <= LAT_W'(RL);
        tagMem[i] <= acceptTag;
      end else if (latMem[i] != '0) begin
        latMem[i] <= latMem[i] - LAT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdPtr      <= '0;
      wrPtr      <= '0;
      busTag     <= '0;
      deliverTag <= '0;
    end else begin
      if (st.push) wrPtr <= nextPtr(wrPtr);
      if (st.pop)  rdPtr <= nextPtr(rdPtr);
      if (st.deliver) deliverTag <= busTag;
      if (st.load)    busTag     <= tagMem[rdPtr];
    end
  end
endmodule

// File: rtl/read_return_sched.sv
module read_return_sched
  import rrs_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int TAG_W = 8,
  parameter int RL    = 6,
  parameter int BURST = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acceptValid,
  input  logic [TAG_W-1:0] acceptTag,
  output logic             busBusy,
  output logic             deliverValid,
  output logic [TAG_W-1:0] deliverTag,
  output logic             overflowErr,
  output logic             collisionErr
);
  rrsStrobes_t st;
  logic headAtOne;

  rrs_ctrl #(.DEPTH(DEPTH), .BURST(BURST)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .acceptValid(acceptValid), .headAtOne(headAtOne),
    .st(st), .busBusy(busBusy), .deliverValid(deliverValid),
    .overflowErr(overflowErr), .collisionErr(collisionErr)
  );

  rrs_datapath #(.DEPTH(DEPTH), .TAG_W(TAG_W), .RL(RL)) u_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .acceptTag(acceptTag),
    .headAtOne(headAtOne), .deliverTag(deliverTag)
  );
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker (
  input logic clk,
  input logic rst_n,
  input logic acceptValid,
  input logic busBusy,
  input logic deliverValid,
  input logic overflowErr,
  input logic collisionErr
);
  assert_deliver_after_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    deliverValid |-> $past(busBusy));
  assert_no_deliver_on_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busBusy) |-> !deliverValid);
  assert_overflow_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overflowErr |-> $past(acceptValid));
  assert_collision_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    collisionErr |-> $past(busBusy));
endmodule

bind read_return_sched rrs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .acceptValid(acceptValid), .busBusy(busBusy),
  .deliverValid(deliverValid), .overflowErr(overflowErr), .collisionErr(collisionErr)
);

// File: tb/read_return_sched_tb.sv
module read_return_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int TAG_W = 8;
  localparam int RL    = 6;
  localparam int BURST = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acceptValid = 1'b0;
  logic [TAG_W-1:0] acceptTag = '0;
  logic busBusy, deliverValid, overflowErr, collisionErr;
  logic [TAG_W-1:0] deliverTag;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  read_return_sched #(.DEPTH(DEPTH), .TAG_W(TAG_W), .RL(RL), .BURST(BURST)) dut_i (
    .clk(clk), .rst_n(rst_n), .acceptValid(acceptValid), .acceptTag(acceptTag),
    .busBusy(busBusy), .deliverValid(deliverValid), .deliverTag(deliverTag),
    .overflowErr(overflowErr), .collisionErr(collisionErr)
  );

  // reference model state
  int mTag[$];
  int mLat[$];
  int mBusLeft = 0;
  int mBusTag = 0;
  bit eDel, eOvf, eColl;
  int eDelTag;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelStep(input bit v, input int tag);
    bit slotFree, headExp, full;
    eDel = 0; eOvf = 0; eColl = 0;
    slotFree = (mBusLeft <= 1);
    if (mBusLeft > 0) begin
      mBusLeft--;
      if (mBusLeft == 0) begin eDel = 1; eDelTag = mBusTag; end
    end
    headExp = (mLat.size() > 0) && (mLat[0] == 1);
    full = (mLat.size() == DEPTH);
    foreach (mLat[i]) if (mLat[i] > 0) mLat[i]--;
    if (headExp) begin
      if (slotFree) begin mBusTag = mTag[0]; mBusLeft = BURST; end
      else eColl = 1;
      void'(mTag.pop_front());
      void'(mLat.pop_front());
    end
    if (v) begin
      if (full) eOvf = 1;
      else begin mTag.push_back(tag); mLat.push_back(RL); end
    end
  endtask

  // one edge: drive, clock, sample off the edge, compare
  task automatic step(input bit v, input int tag);
    acceptValid = v;
    acceptTag = TAG_W'(tag);
    @(posedge clk);
    modelStep(v, tag);
    #1;
    acceptValid = 1'b0;
    chk("R2 busBusy", int'(busBusy), int'(mBusLeft != 0));
    chk("R3 deliverValid", int'(deliverValid), int'(eDel));
    if (eDel) chk("R4 deliverTag", int'(deliverTag), eDelTag);
    chk("R6 overflowErr", int'(overflowErr), int'(eOvf));
    chk("R7 collisionErr", int'(collisionErr), int'(eColl));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    int seen;
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 busBusy reset", int'(busBusy), 0);
    chk("R1 deliverValid reset", int'(deliverValid), 0);
    chk("R1 overflowErr reset", int'(overflowErr), 0);
    chk("R1 collisionErr reset", int'(collisionErr), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2/R3: exact accept-to-delivery latency
    step(1, 8'h11);
    lat = 0;
    seen = 0;
    for (int i = 0; i < RL + BURST + 4 && !seen; i++) begin
      step(0, 0);
      lat++;
      if (deliverValid) seen = 1;
    end
    chk("R2 R3 latency", lat, RL + BURST);
    chk("R3 tag returned", int'(deliverTag), 8'h11);
    idle(4);

    // R5: reads spaced BURST apart go back to back
    step(1, 8'h21);
    idle(BURST - 1);
    step(1, 8'h22);
    seen = 0;
    for (int i = 0; i < RL + 2 * BURST + 2; i++) begin
      step(0, 0);
      if (collisionErr) seen = 1;
    end
    chk("R5 no collision back to back", seen, 0);
    idle(3);

    // R7: reads one cycle apart collide
    step(1, 8'h31);
    step(1, 8'h32);
    seen = 0;
    for (int i = 0; i < RL + BURST + 3; i++) begin
      step(0, 0);
      if (collisionErr) seen++;
    end
    chk("R7 one collision", seen, 1);
    idle(3);

    // R6: overflow by back-to-back accepts
    seen = 0;
    for (int i = 0; i < DEPTH + 2; i++) begin
      step(1, 8'h40 + i);
      if (overflowErr) seen++;
    end
    step(0, 0);
    if (overflowErr) seen++;
    chk("R6 overflow count", seen, 2);
    idle(RL + 3 * BURST * DEPTH);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      step(r < 30, int'($urandom_range(0, 255)));
    end
    idle(RL + 4 * BURST * DEPTH);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule